// File: doc/BRIEF.md
# I2C Engine Register File with Read/Write Aliased Offsets

This block is the 32-bit register front end of an I2C master engine. A simple word-addressed bus writes and reads it. It holds the configuration the engine runs from: a mode word, a FIFO watermark word and an interrupt-enable mask. It also assembles two read-only words from live engine signals: a main status word and an extended status word.

Several offsets mean one thing when read and another when written. The status offset reads status, and a write to it resets the engine. The extended-status offset reads extended status, and a write to it clears the error flags. The interrupt-condition and pending-interrupt offsets take OR-into-mask and AND-into-mask updates when written.

A diagnostic bit in the mode word hands the SCL and SDA pull-down controls to software, which drives them through four write-only strobe offsets. A sticky port-busy indication stays set until software clears it explicitly. Writes and reads of the FIFO and command offsets pass to the engine as one-cycle strobes.

Top module: `i2c_eng_regs`

## Requirements
- R1: Byte offsets decode on address bits above bit 1. Mode is at 0x08 with writable mask 0xFFFFFC0F. Watermark is at 0x0C with writable mask 0x0000F0F0. Interrupt mask is at 0x10 with writable mask 0x0000FFE0. A read returns the addressed word on `bus_rdata` after the next clock edge, and `bus_rdata` holds otherwise. Unused offsets and the command offset 0x04 read as zero.
- R2: A read of 0x14 returns the interrupt condition word. Bits 15..7 are the nine sticky flags, bit 6 is engine busy, bit 5 is engine idle, and all other bits are zero. A write to 0x14 ORs the writable bits of the data into the mask.
- R3: A read of 0x18 returns the condition word ANDed with the mask. A write to 0x18 ANDs the data into the mask.
- R4: A read of 0x1C returns the status word. Bits 31..23 are the flags from invalid-command (bit 31) down to stop-error (bit 23), in the order invalid command, parity, back-end overrun, back-end access, lost arbitration, NACK, data request, command complete, stop error. `evt_flags[8]` maps to bit 31 and `evt_flags[0]` to bit 23. Bits 22..16 hold the highest port number. Bit 15 is set when any pending interrupt exists. Bit 11 is `scl_in`, bit 10 is `sda_in`, bit 9 is port busy, bit 8 is engine busy, and bits 7..0 are `fifo_count`.
- R5: A read of 0x20 returns the extended status word. Bits 31..24 hold the FIFO depth. Bit 9 is the high-water flag, bit 8 the low-water flag, bit 7 port busy, bit 6 engine busy, and bits 4..0 the version.
- R6: A pulse on `evt_flags` sets the matching flag, which stays set. When a pulse and a clear fall in the same cycle, the pulse wins.
- R7: A write to 0x20 clears all nine flags and raises `err_clear` for one cycle. It leaves mode, watermark and mask unchanged and does not raise `eng_reset`.
- R8: A write to 0x1C raises `eng_reset` for one cycle and restores the reset values of mode, watermark and mask. The reset mode has port select bits 15..10 equal to 0. The write also clears the flags and releases both diagnostic pin latches.
- R9: With mode bit 2 (diagnostic) set, writes act on the pins from the next cycle. A write to 0x24 releases SCL and a write to 0x2C pulls SCL low. A write to 0x30 releases SDA and a write to 0x34 pulls SDA low.
- R10: With mode bit 2 clear, `scl_low` and `sda_low` follow `eng_scl_low` and `eng_sda_low` in the same cycle. Writes to 0x24, 0x2C, 0x30 and 0x34 are ignored, so the latch values seen after entering diagnostic mode are unchanged by them.
- R11: A `port_busy_set` pulse sets a sticky port-busy bit. A write to 0x28 with data bit 31 set clears it, and a write without bit 31 does not. An engine reset does not clear it. A read of 0x28 returns it in bit 31.
- R12: A write to 0x00 asserts `fifo_push`, a read of 0x00 asserts `fifo_pop`, and a write to 0x04 asserts `cmd_push`, each combinationally in the same cycle. A read of 0x00 returns `fifo_rdata` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fifo_push | output | 1 | Write to FIFO offset |
| fifo_pop | output | 1 | Read from FIFO offset |
| cmd_push | output | 1 | Write to command offset |
| fifo_rdata | input | 8 | Byte at FIFO head |
| mode_q | output | 32 | Mode word |
| watermark_q | output | 32 | Watermark word |
| int_mask_q | output | 32 | Interrupt mask |
| eng_reset | output | 1 | One-cycle engine reset pulse |
| err_clear | output | 1 | One-cycle error clear pulse |
| evt_flags | input | 9 | Flag set pulses, bit 8 invalid command to bit 0 stop error |
| port_busy_set | input | 1 | Port busy set pulse |
| eng_busy | input | 1 | Engine busy |
| fifo_count | input | 8 | FIFO fill level |
| hi_water | input | 1 | High-water flag |
| lo_water | input | 1 | Low-water flag |
| scl_in | input | 1 | Live SCL level |
| sda_in | input | 1 | Live SDA level |
| eng_scl_low | input | 1 | Engine SCL pull request |
| eng_sda_low | input | 1 | Engine SDA pull request |
| scl_low | output | 1 | SCL pull-down drive |
| sda_low | output | 1 | SDA pull-down drive |

## Verification
Register contents, flags, pin latches, the pulses and `bus_rdata` all change at the first clock edge after the bus or event cycle. The bench drives just after a falling edge and compares at the following falling edge. The FIFO and command strobes, and the pin drive outside diagnostic mode, are combinational. They are therefore sampled in the same cycle, after the drive has settled and before the next rising edge. A reference model updated at every rising edge holds the registered state, and all registered outputs are compared against it at every falling edge.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   // word indexes (byte offset / 4)
   localparam int W_FIFO     = 0;
   localparam int W_CMD      = 1;
   localparam int W_MODE     = 2;
   localparam int W_WMARK    = 3;
   localparam int W_IMASK    = 4;
   localparam int W_IOR      = 5;
   localparam int W_IAND     = 6;
   localparam int W_STAT     = 7;
   localparam int W_ESTAT    = 8;
   localparam int W_SCL_REL  = 9;
   localparam int W_PBUSY    = 10;
   localparam int W_SCL_PULL = 11;
   localparam int W_SDA_REL  = 12;
   localparam int W_SDA_PULL = 13;
   localparam int W_LAST     = 13;

   localparam int NFLAG = 9;
   localparam logic [31:0] MODE_WMASK  = 32'hFFFF_FC0F;
   localparam logic [31:0] WMARK_WMASK = 32'h0000_F0F0;
   localparam logic [31:0] IMASK_WMASK = 32'h0000_FFE0;
   localparam int MODE_DIAG_BIT = 2;

   typedef logic [NFLAG-1:0] flag_t;
endpackage

// File: rtl/i2cr_decode.sv
module i2cr_decode #(
   parameter int ADDR_W = 6,
   localparam int NW = 2 ** (ADDR_W - 2)
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic [NW-1:0]     wr_hit
);
   logic unused_lo;
   assign unused_lo = ^addr[1:0];

   for (genvar g = 0; g < NW; g++) begin : g_hit
      assign wr_hit[g] = wr && (addr[ADDR_W-1:2] == (ADDR_W-2)'(g));
   end
endmodule

// File: rtl/i2cr_sticky.sv
module i2cr_sticky #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic         clr,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("i2cr_sticky: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[b] <= 1'b0;
         else if (set[b]) q[b] <= 1'b1;
         else if (clr)    q[b] <= 1'b0;
      end
   end

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((q & $past(set)) == $past(set)));
   // R7
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && set == '0) |=> (q == '0));
endmodule

// File: rtl/i2cr_pin_ctl.sv
module i2cr_pin_ctl #(
   parameter int NPIN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            diag,
   input  logic            flush,
   input  logic [NPIN-1:0] rel,
   input  logic [NPIN-1:0] pull,
   input  logic [NPIN-1:0] eng_low,
   output logic [NPIN-1:0] pin_low
);
   logic [NPIN-1:0] latch_q;

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                latch_q[p] <= 1'b0;
         else if (flush)            latch_q[p] <= 1'b0;
         else if (diag && pull[p])  latch_q[p] <= 1'b1;
         else if (diag && rel[p])   latch_q[p] <= 1'b0;
      end
      assign pin_low[p] = diag ? latch_q[p] : eng_low[p];

      // R9
      pull_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (diag && pull[p] && !flush) |=> latch_q[p]);
      // R10
      strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!diag && !flush) |=> $stable(latch_q[p]));
   end
endmodule

// File: rtl/i2c_eng_regs.sv
module i2c_eng_regs
   import i2cr_pkg::*;
#(
   parameter int          ADDR_W     = 6,
   parameter int          MAX_PORT   = 3,
   parameter int          FIFO_DEPTH = 8,
   parameter int          VERSION    = 4,
   parameter logic [31:0] MODE_RST   = 32'h0006_0008,
   parameter logic [31:0] WMARK_RST  = 32'h0000_4040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              fifo_push,
   output logic              fifo_pop,
   output logic              cmd_push,
   input  logic [7:0]        fifo_rdata,
   output logic [31:0]       mode_q,
   output logic [31:0]       watermark_q,
   output logic [31:0]       int_mask_q,
   output logic              eng_reset,
   output logic              err_clear,
   input  logic [8:0]        evt_flags,
   input  logic              port_busy_set,
   input  logic              eng_busy,
   input  logic [7:0]        fifo_count,
   input  logic              hi_water,
   input  logic              lo_water,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              eng_scl_low,
   input  logic              eng_sda_low,
   output logic              scl_low,
   output logic              sda_low
);
   localparam int NW    = 2 ** (ADDR_W - 2);
   localparam int IDX_W = ADDR_W - 2;
   localparam logic [6:0] MAXP_F = 7'(MAX_PORT);
   localparam logic [7:0] DEPTH_F = 8'(FIFO_DEPTH);
   localparam logic [4:0] VER_F = 5'(VERSION);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("i2c_eng_regs: ADDR_W must reach offset 0x34");
   end
   if (MAX_PORT < 0 || MAX_PORT > 127) begin : g_bad_port
      $error("i2c_eng_regs: MAX_PORT must fit 7 bits");
   end
   if (FIFO_DEPTH < 1 || FIFO_DEPTH > 255) begin : g_bad_depth
      $error("i2c_eng_regs: FIFO_DEPTH must fit 8 bits");
   end
   if (VERSION < 0 || VERSION > 31) begin : g_bad_ver
      $error("i2c_eng_regs: VERSION must fit 5 bits");
   end
   if (MODE_RST[15:10] != 6'd0) begin : g_bad_mode
      $error("i2c_eng_regs: reset port select must be 0");
   end

   logic [NW-1:0] wr_hit;
   logic unused_hit;
   assign unused_hit = ^wr_hit[NW-1:W_LAST+1];

   i2cr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .wr(bus_wr), .addr(bus_addr), .wr_hit(wr_hit)
   );

   logic [IDX_W-1:0] rd_idx;
   assign rd_idx = bus_addr[ADDR_W-1:2];

   assign fifo_push = wr_hit[W_FIFO];
   assign cmd_push  = wr_hit[W_CMD];
   assign fifo_pop  = bus_rd && (rd_idx == IDX_W'(W_FIFO));

   logic eng_rst_w, err_clr_w;
   assign eng_rst_w = wr_hit[W_STAT];
   assign err_clr_w = wr_hit[W_ESTAT];

   // sticky flags and port busy
   flag_t flags_q;
   logic  pbusy_q;

   i2cr_sticky #(.W(NFLAG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(evt_flags),
      .clr(eng_rst_w || err_clr_w), .q(flags_q)
   );
   i2cr_sticky #(.W(1)) u_pbusy (
      .clk(clk), .rst_n(rst_n), .set(port_busy_set),
      .clr(wr_hit[W_PBUSY] && bus_wdata[31]), .q(pbusy_q)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= MODE_RST & MODE_WMASK;
         watermark_q <= WMARK_RST & WMARK_WMASK;
         int_mask_q  <= '0;
      end else if (eng_rst_w) begin
         mode_q      <= MODE_RST & MODE_WMASK;
         watermark_q <= WMARK_RST & WMARK_WMASK;
         int_mask_q  <= '0;
      end else begin
         if (wr_hit[W_MODE])  mode_q      <= bus_wdata & MODE_WMASK;
         if (wr_hit[W_WMARK]) watermark_q <= bus_wdata & WMARK_WMASK;
         if (wr_hit[W_IMASK])     int_mask_q <= bus_wdata & IMASK_WMASK;
         else if (wr_hit[W_IOR])  int_mask_q <= int_mask_q | (bus_wdata & IMASK_WMASK);
         else if (wr_hit[W_IAND]) int_mask_q <= int_mask_q & bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_reset <= 1'b0;
         err_clear <= 1'b0;
      end else begin
         eng_reset <= eng_rst_w;
         err_clear <= err_clr_w;
      end
   end

   // diagnostic pin control
   logic diag;
   assign diag = mode_q[MODE_DIAG_BIT];

   i2cr_pin_ctl #(.NPIN(2)) u_pins (
      .clk(clk), .rst_n(rst_n), .diag(diag), .flush(eng_rst_w),
      .rel({wr_hit[W_SDA_REL], wr_hit[W_SCL_REL]}),
      .pull({wr_hit[W_SDA_PULL], wr_hit[W_SCL_PULL]}),
      .eng_low({eng_sda_low, eng_scl_low}),
      .pin_low({sda_low, scl_low})
   );

   // composed read words
   logic [31:0] cond_w, pend_w, stat_w, estat_w;
   assign cond_w  = {16'b0, flags_q, eng_busy, ~eng_busy, 5'b0};
   assign pend_w  = cond_w & int_mask_q;
   assign stat_w  = {flags_q, MAXP_F, |pend_w, 3'b0, scl_in, sda_in,
                     pbusy_q, eng_busy, fifo_count};
   assign estat_w = {DEPTH_F, 14'b0, hi_water, lo_water, pbusy_q, eng_busy,
                     1'b0, VER_F};

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (int'(rd_idx))
         W_FIFO:   rd_mux = {24'b0, fifo_rdata};
         W_MODE:   rd_mux = mode_q;
         W_WMARK:  rd_mux = watermark_q;
         W_IMASK:  rd_mux = int_mask_q;
         W_IOR:    rd_mux = cond_w;
         W_IAND:   rd_mux = pend_w;
         W_STAT:   rd_mux = stat_w;
         W_ESTAT:  rd_mux = estat_w;
         W_PBUSY:  rd_mux = {pbusy_q, 31'b0};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   // R8
   eng_rst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst_w |=> (eng_reset && mode_q[15:10] == 6'd0 && int_mask_q == '0));
   // R7
   err_clr_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr_w |=> (err_clear && !eng_reset && $stable(mode_q) && $stable(int_mask_q)));
   // R2
   mask_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[W_IOR] |=> ((int_mask_q & $past(int_mask_q)) == $past(int_mask_q)));
   // R3
   mask_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[W_IAND] |=> ((int_mask_q & ~$past(int_mask_q)) == '0));
   // R1
   rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && rd_idx == IDX_W'(W_MODE)) |=> (bus_rdata == $past(mode_q)));
   // R11
   pbusy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pbusy_q && !(wr_hit[W_PBUSY] && bus_wdata[31])) |=> pbusy_q);
endmodule

// File: tb/i2c_eng_regs_test.sv
`timescale 1ns/100ps
module i2c_eng_regs_test;
   localparam logic [31:0] MODE_DEF = 32'h0006_0008;
   localparam logic [31:0] WM_DEF   = 32'h0000_4040;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 0, bus_rd = 0;
   logic [5:0] bus_addr = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic fifo_push, fifo_pop, cmd_push;
   logic [7:0] fifo_rdata = 0;
   logic [31:0] mode_q, watermark_q, int_mask_q;
   logic eng_reset, err_clear;
   logic [8:0] evt_flags = 0;
   logic port_busy_set = 0, eng_busy = 0;
   logic [7:0] fifo_count = 0;
   logic hi_water = 0, lo_water = 0, scl_in = 1, sda_in = 1;
   logic eng_scl_low = 0, eng_sda_low = 0;
   logic scl_low, sda_low;

   int checks = 0, errors = 0;
   string cur_req = "R8";
   bit done = 0;

   always #2 clk = ~clk;

   i2c_eng_regs uut (.*);

   // reference model state
   logic [31:0] m_mode = MODE_DEF, m_wm = WM_DEF, m_mask = 0, m_rdata = 0;
   logic [8:0]  m_flags = 0;
   logic m_pbusy = 0, m_dscl = 0, m_dsda = 0, m_rst = 0, m_clr = 0;

   function automatic logic [31:0] m_read(int w);
      logic [31:0] cond;
      cond = {16'b0, m_flags, eng_busy, ~eng_busy, 5'b0};
      case (w)
         0: return {24'b0, fifo_rdata};
         2: return m_mode;
         3: return m_wm;
         4: return m_mask;
         5: return cond;
         6: return cond & m_mask;
         7: return {m_flags, 7'd3, |(cond & m_mask), 3'b0, scl_in, sda_in,
                    m_pbusy, eng_busy, fifo_count};
         8: return {8'd8, 14'b0, hi_water, lo_water, m_pbusy, eng_busy, 1'b0, 5'd4};
         10: return {m_pbusy, 31'b0};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      int w;
      logic clrf;
      w = int'(bus_addr[5:2]);
      if (rst_n) begin
         if (bus_rd) m_rdata = m_read(w);
         m_rst = bus_wr && w == 7;
         m_clr = bus_wr && w == 8;
         clrf = m_rst || m_clr;
         m_flags = (clrf ? 9'h0 : m_flags) | evt_flags;
         m_pbusy = ((bus_wr && w == 10 && bus_wdata[31]) ? 1'b0 : m_pbusy) | port_busy_set;
         if (m_rst) begin
            m_mode = MODE_DEF; m_wm = WM_DEF; m_mask = 0; m_dscl = 0; m_dsda = 0;
         end else if (bus_wr) begin
            if (m_mode[2]) begin
               if (w == 9)  m_dscl = 0;
               if (w == 11) m_dscl = 1;
               if (w == 12) m_dsda = 0;
               if (w == 13) m_dsda = 1;
            end
            case (w)
               2: m_mode = bus_wdata & 32'hFFFF_FC0F;
               3: m_wm = bus_wdata & 32'h0000_F0F0;
               4: m_mask = bus_wdata & 32'h0000_FFE0;
               5: m_mask = m_mask | (bus_wdata & 32'h0000_FFE0);
               6: m_mask = m_mask & bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(bus_rdata, m_rdata, {cur_req, " rdata"});
         chk(mode_q, m_mode, {cur_req, " mode"});
         chk(watermark_q, m_wm, {cur_req, " watermark"});
         chk(int_mask_q, m_mask, {cur_req, " mask"});
         chk({31'b0, eng_reset}, {31'b0, m_rst}, {cur_req, " eng_reset"});
         chk({31'b0, err_clear}, {31'b0, m_clr}, {cur_req, " err_clear"});
         chk({31'b0, scl_low}, {31'b0, m_mode[2] ? m_dscl : eng_scl_low}, {cur_req, " scl_low"});
         chk({31'b0, sda_low}, {31'b0, m_mode[2] ? m_dsda : eng_sda_low}, {cur_req, " sda_low"});
      end
   end

   task automatic cyc(logic wr, logic rd, logic [5:0] a, logic [31:0] d,
                      logic [8:0] ev, logic ps);
      @(negedge clk); #1;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      evt_flags = ev; port_busy_set = ps;
      @(negedge clk); #1;
      bus_wr = 0; bus_rd = 0; evt_flags = 0; port_busy_set = 0;
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      cyc(1, 0, a, d, 9'h0, 0);
   endtask

   task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string tag);
      @(negedge clk); #1;
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      chk(bus_rdata, exp, tag);
      #1 bus_rd = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      eng_busy = 1; fifo_count = 8'h05; scl_in = 1; sda_in = 0; hi_water = 1;

      cur_req = "R8";
      rd_chk(6'h08, MODE_DEF, "R8 reset mode");
      rd_chk(6'h0C, WM_DEF, "R8 reset watermark");

      cur_req = "R1";
      wr(6'h08, 32'hFFFF_FFFF);
      rd_chk(6'h08, 32'hFFFF_FC0F, "R1 mode writable bits");
      wr(6'h08, 32'h0012_3408);
      rd_chk(6'h08, 32'h0012_3408, "R1 mode readback");
      wr(6'h0C, 32'hFFFF_FFFF);
      rd_chk(6'h0C, 32'h0000_F0F0, "R1 watermark mask");
      wr(6'h10, 32'hFFFF_FFFF);
      rd_chk(6'h10, 32'h0000_FFE0, "R1 int mask");
      rd_chk(6'h04, 32'h0, "R1 command reads zero");

      cur_req = "R2";
      wr(6'h10, 32'h0);
      wr(6'h14, 32'h0000_0300);
      wr(6'h14, 32'h0000_8000);
      chk(int_mask_q, 32'h0000_8300, "R2 OR into mask");
      rd_chk(6'h14, 32'h0000_0040, "R2 condition busy");

      cur_req = "R3";
      cyc(0, 0, 6'h00, 0, 9'h002, 0);
      rd_chk(6'h18, 32'h0000_0100, "R3 pending");
      wr(6'h18, 32'h0000_8000);
      chk(int_mask_q, 32'h0000_8000, "R3 AND into mask");
      rd_chk(6'h18, 32'h0, "R3 pending after AND");

      cur_req = "R4";
      rd_chk(6'h1C, 32'h0103_0905, "R4 status word");
      cur_req = "R5";
      rd_chk(6'h20, 32'h0800_0244, "R5 extended status");

      cur_req = "R6";
      cyc(1, 0, 6'h20, 0, 9'h100, 0);
      rd_chk(6'h1C, 32'h8003_8905, "R6 set beats clear");

      cur_req = "R7";
      wr(6'h20, 32'h0);
      chk({31'b0, err_clear}, 32'h1, "R7 err_clear pulse");
      chk({31'b0, eng_reset}, 32'h0, "R7 no engine reset");
      rd_chk(6'h08, 32'h0012_3408, "R7 mode kept");
      rd_chk(6'h0C, 32'h0000_F0F0, "R7 watermark kept");
      rd_chk(6'h1C, 32'h0003_0905, "R7 flags cleared");

      cur_req = "R9";
      wr(6'h08, 32'h0006_000C);
      wr(6'h2C, 32'h0);
      chk({31'b0, scl_low}, 32'h1, "R9 SCL pulled");
      wr(6'h34, 32'h0);
      chk({31'b0, sda_low}, 32'h1, "R9 SDA pulled");
      wr(6'h24, 32'h0);
      chk({31'b0, scl_low}, 32'h0, "R9 SCL released");
      wr(6'h30, 32'h0);
      chk({31'b0, sda_low}, 32'h0, "R9 SDA released");

      cur_req = "R10";
      wr(6'h08, 32'h0006_0008);
      @(negedge clk); #1 eng_scl_low = 1;
      #0.5 chk({31'b0, scl_low}, 32'h1, "R10 SCL follows engine");
      wr(6'h34, 32'h0);
      chk({31'b0, sda_low}, 32'h0, "R10 SDA strobe ignored");
      @(negedge clk); #1 eng_scl_low = 0;
      wr(6'h08, 32'h0006_000C);
      chk({31'b0, sda_low}, 32'h0, "R10 latch untouched");

      cur_req = "R8";
      wr(6'h2C, 32'h0);
      wr(6'h10, 32'hFFFF_FFFF);
      cyc(0, 0, 6'h00, 0, 9'h0, 1);
      hi_water = 0; lo_water = 1;
      wr(6'h1C, 32'h0);
      chk({31'b0, eng_reset}, 32'h1, "R8 reset pulse");
      chk(mode_q, MODE_DEF, "R8 mode default");
      chk(int_mask_q, 32'h0, "R8 mask default");
      chk(watermark_q, WM_DEF, "R8 watermark default");
      chk({31'b0, scl_low}, 32'h0, "R8 SCL released");

      cur_req = "R11";
      rd_chk(6'h20, 32'h0800_01C4, "R11 busy survives reset");
      rd_chk(6'h28, 32'h8000_0000, "R11 read busy");
      wr(6'h28, 32'h7FFF_FFFF);
      rd_chk(6'h28, 32'h8000_0000, "R11 no clear without bit31");
      wr(6'h28, 32'h8000_0000);
      rd_chk(6'h28, 32'h0, "R11 cleared");

      cur_req = "R12";
      @(negedge clk); #1 bus_wr = 1; bus_addr = 6'h00;
      #0.5 chk({29'b0, fifo_push, fifo_pop, cmd_push}, 32'h4, "R12 fifo push");
      @(negedge clk); #1 bus_addr = 6'h04;
      #0.5 chk({29'b0, fifo_push, fifo_pop, cmd_push}, 32'h1, "R12 cmd push");
      @(negedge clk); #1 bus_wr = 0;
      fifo_rdata = 8'hA5;
      @(negedge clk); #1 bus_rd = 1; bus_addr = 6'h00;
      #0.5 chk({29'b0, fifo_push, fifo_pop, cmd_push}, 32'h2, "R12 fifo pop");
      @(negedge clk);
      chk(bus_rdata, 32'h0000_00A5, "R12 fifo data");
      #1 bus_rd = 0;

      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule